// File: doc/BRIEF.md
# JTAG Identification Register Set

This block holds the identification data registers that sit behind a JTAG test access port. There are three of them: a fixed 32-bit IDCODE, a 32-bit USERCODE set when the part is programmed, and a 256-bit customer code. A separate customer code exists for each design revision, and it can only be read under a private instruction. The TAP controller decodes the instruction and passes in three select lines together with the capture-DR and shift-DR strobes. The block drives TDO from whichever register is selected.

The programmed values come in on plain inputs that stand for nonvolatile storage. Each one has a valid flag, and there is also a device-blank flag. Storage that is blank, never programmed or erased reads back as all ones. The IDCODE version nibble comes from an input. The family code, product ID and manufacturer ID are parameters.

Top module: `jtag_ident_regs`

## Requirements
- R1: When IDCODE is captured, the register loads {version_i[3:0], FAMILY_CODE[7:0], PRODUCT_ID[7:0], MFR_ID[10:0], 1'b1}, listed from bit 31 down to bit 0.
- R2: The first bit shifted out after an IDCODE capture is always 1.
- R3: When USERCODE is captured while user_valid_i=1 and blank_i=0, the register loads user_code_i.
- R4: When USERCODE is captured while blank_i=1 or user_valid_i=0, the register loads 32'hFFFFFFFF.
- R5: When the customer code is captured while blank_i=0, rev_sel_i=r<NUM_REV and cust_valid_i[r]=1, the register loads cust_code_i[r*256 +: 256]. Bit 0 of that slice is shifted out first.
- R6: The customer code captures as all 256 ones when blank_i=1, when cust_valid_i[rev_sel_i]=0 (not loaded or erased), or when rev_sel_i>=NUM_REV.
- R7: Each register is captured on a TCK rising edge with capture_dr_i=1. On each TCK rising edge with shift_dr_i=1 and capture_dr_i=0, it shifts one place toward the LSB and TDI enters at the MSB. tdo_o is the LSB of the selected register. After W shifts, the TDI bits appear on tdo_o in the order they were sent.
- R8: rev_sel_i is used only at capture. Changing it while shifting does not alter the bits shifted out.
- R9: The selects have a fixed priority: IDCODE over USERCODE over customer code. With no select active, tdo_o is 0.
- R10: While rst_ni is low, all registers are cleared and tdo_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_idcode_i | input | 1 | IDCODE instruction decoded |
| sel_usercode_i | input | 1 | USERCODE instruction decoded |
| sel_custcode_i | input | 1 | Private customer-code instruction decoded |
| capture_dr_i | input | 1 | Capture-DR strobe |
| shift_dr_i | input | 1 | Shift-DR strobe |
| tdi_i | input | 1 | Serial data in |
| version_i | input | 4 | Die version for IDCODE bits 31:28 |
| rev_sel_i | input | REV_W | Selected design revision |
| blank_i | input | 1 | Device is blank |
| user_code_i | input | 32 | Programmed USERCODE |
| user_valid_i | input | 1 | USERCODE was programmed |
| cust_code_i | input | NUM_REV*256 | Customer codes, revision r at bits r*256 and up |
| cust_valid_i | input | NUM_REV | Customer code loaded and not erased, per revision |
| tdo_o | output | 1 | Serial data out |

## Verification
The bench builds the block with NUM_REV=3, so REV_W is 2 and the revision code 3 is out of range. That setting lets a sweep cover every combination of per-revision valid mask, blank flag and revision code, which includes the out-of-range default. All sixteen version nibbles are tried on the IDCODE. The USERCODE is read with edge patterns under each combination of valid and blank. A revision change in the middle of a shift checks that the revision is only used at capture.

// File: rtl/jtag_ident_pkg.sv
package jtag_ident_pkg;
  localparam int unsigned ID_W       = 32;
  localparam int unsigned CUST_BYTES = 32;
  localparam int unsigned CUST_W     = CUST_BYTES * 8;

  typedef enum logic [1:0] {
    DR_NONE,
    DR_IDCODE,
    DR_USERCODE,
    DR_CUSTCODE
  } dr_sel_e;

  // fixed priority: idcode > usercode > custcode
  function automatic dr_sel_e pick_dr(logic id, logic usr, logic cust);
    if (id)        return DR_IDCODE;
    else if (usr)  return DR_USERCODE;
    else if (cust) return DR_CUSTCODE;
    else           return DR_NONE;
  endfunction
endpackage

// File: rtl/idcode_value.sv
module idcode_value #(
  parameter logic [7:0]  FAMILY_CODE = 8'h46,
  parameter logic [7:0]  PRODUCT_ID  = 8'h5A,
  parameter logic [10:0] MFR_ID      = 11'h049
) (
  input  logic [3:0]  version_i,
  output logic [31:0] value_o
);
  assign value_o = {version_i, FAMILY_CODE, PRODUCT_ID, MFR_ID, 1'b1};
endmodule

// File: rtl/cust_code_select.sv
module cust_code_select
  import jtag_ident_pkg::*;
#(
  parameter int unsigned NUM_REV = 4,
  parameter int unsigned REV_W   = 2
) (
  input  logic [REV_W-1:0]          rev_i,
  input  logic                      blank_i,
  input  logic [NUM_REV-1:0]        valid_i,
  input  logic [NUM_REV*CUST_W-1:0] codes_i,
  output logic [CUST_W-1:0]         value_o
);
  logic [CUST_W-1:0] slice_q [NUM_REV];

  for (genvar r = 0; r < NUM_REV; r++) begin : g_rev
    assign slice_q[r] = valid_i[r] ? codes_i[r*CUST_W +: CUST_W] : '1;
  end

  always_comb begin
    value_o = '1;
    if (!blank_i) begin
      for (int r = 0; r < NUM_REV; r++) begin
        if (REV_W'(r) == rev_i) value_o = slice_q[r];
      end
    end
  end
endmodule

// File: rtl/dr_shifter.sv
module dr_shifter #(
  parameter int unsigned W = 32
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         tdi_i,
  input  logic [W-1:0] cap_val_i,
  output logic         lsb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (en_i) begin
      if (capture_i)    sr_q <= cap_val_i;
      else if (shift_i) sr_q <= {tdi_i, sr_q[W-1:1]};
    end
  end

  assign lsb_o = sr_q[0];
endmodule

// File: rtl/jtag_ident_regs.sv
module jtag_ident_regs
  import jtag_ident_pkg::*;
#(
  parameter logic [7:0]  FAMILY_CODE = 8'h46,
  parameter logic [7:0]  PRODUCT_ID  = 8'h5A,
  parameter logic [10:0] MFR_ID      = 11'h049,
  parameter int unsigned NUM_REV     = 4,
  localparam int unsigned REV_W      = (NUM_REV > 1) ? $clog2(NUM_REV) : 1
) (
  input  logic                      tck_i,
  input  logic                      rst_ni,
  input  logic                      sel_idcode_i,
  input  logic                      sel_usercode_i,
  input  logic                      sel_custcode_i,
  input  logic                      capture_dr_i,
  input  logic                      shift_dr_i,
  input  logic                      tdi_i,
  input  logic [3:0]                version_i,
  input  logic [REV_W-1:0]          rev_sel_i,
  input  logic                      blank_i,
  input  logic [ID_W-1:0]           user_code_i,
  input  logic                      user_valid_i,
  input  logic [NUM_REV*CUST_W-1:0] cust_code_i,
  input  logic [NUM_REV-1:0]        cust_valid_i,
  output logic                      tdo_o
);
  dr_sel_e           dr_sel;
  logic [ID_W-1:0]   id_val, user_val;
  logic [CUST_W-1:0] cust_val;
  logic              id_lsb, user_lsb, cust_lsb;

  assign dr_sel = pick_dr(sel_idcode_i, sel_usercode_i, sel_custcode_i);

  idcode_value #(
    .FAMILY_CODE(FAMILY_CODE),
    .PRODUCT_ID (PRODUCT_ID),
    .MFR_ID     (MFR_ID)
  ) u_id_val (
    .version_i(version_i),
    .value_o  (id_val)
  );

  assign user_val = (blank_i || !user_valid_i) ? '1 : user_code_i;

  cust_code_select #(
    .NUM_REV(NUM_REV),
    .REV_W  (REV_W)
  ) u_cust_val (
    .rev_i  (rev_sel_i),
    .blank_i(blank_i),
    .valid_i(cust_valid_i),
    .codes_i(cust_code_i),
    .value_o(cust_val)
  );

  dr_shifter #(.W(ID_W)) u_id_sr (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .en_i     (dr_sel == DR_IDCODE),
    .capture_i(capture_dr_i),
    .shift_i  (shift_dr_i),
    .tdi_i    (tdi_i),
    .cap_val_i(id_val),
    .lsb_o    (id_lsb)
  );

  dr_shifter #(.W(ID_W)) u_user_sr (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .en_i     (dr_sel == DR_USERCODE),
    .capture_i(capture_dr_i),
    .shift_i  (shift_dr_i),
    .tdi_i    (tdi_i),
    .cap_val_i(user_val),
    .lsb_o    (user_lsb)
  );

  dr_shifter #(.W(CUST_W)) u_cust_sr (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .en_i     (dr_sel == DR_CUSTCODE),
    .capture_i(capture_dr_i),
    .shift_i  (shift_dr_i),
    .tdi_i    (tdi_i),
    .cap_val_i(cust_val),
    .lsb_o    (cust_lsb)
  );

  always_comb begin
    unique case (dr_sel)
      DR_IDCODE:   tdo_o = id_lsb;
      DR_USERCODE: tdo_o = user_lsb;
      DR_CUSTCODE: tdo_o = cust_lsb;
      default:     tdo_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/jtag_ident_regs_chk.sv
module jtag_ident_regs_chk (
  input logic tck_i,
  input logic rst_ni,
  input logic sel_idcode_i,
  input logic sel_usercode_i,
  input logic sel_custcode_i,
  input logic capture_dr_i,
  input logic shift_dr_i,
  input logic blank_i,
  input logic user_valid_i,
  input logic tdo_o
);
  // R2
  id_lsb_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_dr_i && sel_idcode_i |=> (!sel_idcode_i || tdo_o));

  // R4
  user_blank_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_dr_i && sel_usercode_i && !sel_idcode_i && (blank_i || !user_valid_i)
    |=> (sel_idcode_i || !sel_usercode_i || tdo_o));

  // R6
  cust_blank_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_dr_i && sel_custcode_i && !sel_idcode_i && !sel_usercode_i && blank_i
    |=> (sel_idcode_i || sel_usercode_i || !sel_custcode_i || tdo_o));

  // R9
  idle_tdo_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel_idcode_i && !sel_usercode_i && !sel_custcode_i |-> !tdo_o);

  // R7
  hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !capture_dr_i && !shift_dr_i
    |=> (!$stable({sel_idcode_i, sel_usercode_i, sel_custcode_i}) || $stable(tdo_o)));
endmodule

bind jtag_ident_regs jtag_ident_regs_chk u_chk (.*);

// File: tb/sim_jtag_ident_regs.sv
`timescale 1ns/1ps
module sim_jtag_ident_regs;
  localparam int NREV = 3;
  localparam int CW   = 256;
  localparam logic [7:0]  FAM = 8'h46;
  localparam logic [7:0]  PID = 8'h5A;
  localparam logic [10:0] MFR = 11'h049;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_id = 1'b0, sel_usr = 1'b0, sel_cust = 1'b0;
  logic cap = 1'b0, shf = 1'b0, tdi = 1'b0;
  logic [3:0] ver = '0;
  logic [1:0] rev = '0;
  logic blank = 1'b0;
  logic [31:0] ucode = '0;
  logic uvalid = 1'b0;
  logic [NREV*CW-1:0] ccode;
  logic [NREV-1:0] cvalid = '0;
  logic tdo;
  int vectors = 0, errs = 0;

  always #2 clk = ~clk;

  jtag_ident_regs #(
    .FAMILY_CODE(FAM), .PRODUCT_ID(PID), .MFR_ID(MFR), .NUM_REV(NREV)
  ) u0 (
    .tck_i(clk), .rst_ni(rst_n),
    .sel_idcode_i(sel_id), .sel_usercode_i(sel_usr), .sel_custcode_i(sel_cust),
    .capture_dr_i(cap), .shift_dr_i(shf), .tdi_i(tdi),
    .version_i(ver), .rev_sel_i(rev), .blank_i(blank),
    .user_code_i(ucode), .user_valid_i(uvalid),
    .cust_code_i(ccode), .cust_valid_i(cvalid),
    .tdo_o(tdo)
  );

  function automatic logic [CW-1:0] cust_pat(int r);
    logic [CW-1:0] v;
    for (int j = 0; j < CW/8; j++) v[j*8 +: 8] = 8'((r*37 + j*5 + 1) & 8'hFF);
    return v;
  endfunction

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic scan(input int n, input logic [511:0] tin, input int chg_at,
                      input logic [1:0] chg_rev, output logic [511:0] got);
    got = '0;
    @(negedge clk); cap = 1'b1;
    @(posedge clk);
    @(negedge clk); cap = 1'b0;
    for (int i = 0; i < n; i++) begin
      #1 got[i] = tdo;
      if (i == chg_at) rev = chg_rev;
      shf = 1'b1; tdi = tin[i];
      @(posedge clk);
      @(negedge clk);
    end
    shf = 1'b0; tdi = 1'b0;
  endtask

  initial begin
    #(4*150000);
    errs++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [511:0] got, exp;
    logic [31:0] upat [5];
    upat[0] = 32'h0000_0000; upat[1] = 32'hFFFF_FFFF; upat[2] = 32'hA5C3_1E70;
    upat[3] = 32'h0000_0001; upat[4] = 32'h8000_0000;
    for (int r = 0; r < NREV; r++) ccode[r*CW +: CW] = cust_pat(r);

    // R10 reset state
    sel_id = 1'b1;
    #5 chk("R10 reset tdo", 512'(tdo), 512'(0));
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 all versions
    for (int v = 0; v < 16; v++) begin
      ver = 4'(v);
      scan(32, '0, -1, 2'd0, got);
      chk("R1 R2 idcode", got, 512'({4'(v), FAM, PID, MFR, 1'b1}));
    end
    sel_id = 1'b0;

    // R3 R4 usercode sweep
    sel_usr = 1'b1;
    for (int p = 0; p < 5; p++)
      for (int c = 0; c < 4; c++) begin
        ucode = upat[p]; uvalid = c[0]; blank = c[1];
        scan(32, '0, -1, 2'd0, got);
        exp = (uvalid && !blank) ? 512'(ucode) : 512'(32'hFFFF_FFFF);
        chk((uvalid && !blank) ? "R3 usercode" : "R4 usercode blank", got, exp);
      end
    blank = 1'b0; uvalid = 1'b1; ucode = 32'h1357_9BDF;

    // R7 tdi passthrough
    scan(64, 512'(64'hC0DE_F00D_0000_0000) | 512'(32'h6B2E_91D4), -1, 2'd0, got);
    chk("R7 capture part", 512'(got[31:0]), 512'(32'h1357_9BDF));
    chk("R7 tdi passthrough", 512'(got[63:32]), 512'(32'h6B2E_91D4));
    sel_usr = 1'b0;

    // R5 R6 custcode sweep
    sel_cust = 1'b1;
    for (int m = 0; m < 8; m++)
      for (int b = 0; b < 2; b++)
        for (int r = 0; r < 4; r++) begin
          cvalid = 3'(m); blank = b[0]; rev = 2'(r);
          scan(CW, '0, -1, 2'd0, got);
          if (!blank && r < NREV && cvalid[r]) begin
            exp = 512'(cust_pat(r));
            chk("R5 custcode", got, exp);
          end else begin
            exp = 512'({CW{1'b1}});
            chk("R6 custcode blank", got, exp);
          end
        end
    blank = 1'b0; cvalid = '1;

    // R8 revision change mid shift
    rev = 2'd0;
    scan(CW, '0, 10, 2'd1, got);
    chk("R8 rev change mid shift", got, 512'(cust_pat(0)));
    scan(CW, '0, -1, 2'd1, got);
    chk("R8 rev used at next capture", got, 512'(cust_pat(1)));

    // R9 priority
    sel_id = 1'b1; sel_usr = 1'b1; ver = 4'hA;
    scan(32, '0, -1, 2'd0, got);
    chk("R9 idcode over others", got, 512'({4'hA, FAM, PID, MFR, 1'b1}));
    sel_id = 1'b0;
    scan(32, '0, -1, 2'd0, got);
    chk("R9 usercode over custcode", got, 512'(32'h1357_9BDF));
    sel_usr = 1'b0; sel_cust = 1'b0;
    scan(8, 512'(8'hFF), -1, 2'd0, got);
    chk("R9 idle tdo", got, 512'(0));

    report();
  end
endmodule